// File: doc/BRIEF.md
# Duty-Cycled Receiver Polling Controller

This controller saves power in a radio receiver by keeping it asleep most of the time. At intervals it wakes the signal path, waits for it to settle, and then checks whether the incoming demodulated data has the edge timing of a real transmitter. If the timing is right, the receiver stays on and passes data through to the host. If it is wrong, the controller goes back to sleep. Only the timing logic runs while the receiver sleeps.

The sleep interval is a 5-bit sleep word times an extension factor times a base unit of clock cycles. A 2-bit baud-range code sets both the settling wait and the window of accepted edge spacings. The number of accepted intervals needed to pass the check is configurable. The host can end reception at any time by holding the enable line low.

Top module: `rx_poll_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `state_o` is 0 (sleep), `path_en` is low and `data_out` is low, whatever `data_in` is.
- R2: `state_o` codes the phase as 0 = sleep, 1 = start-up, 2 = bit-check, 3 = receiving. Sleep only leads to start-up. Start-up never leads straight to receiving. Receiving is entered only from bit-check.
- R3: `path_en` is low in sleep and high in every other phase.
- R4: Sleep lasts max(`sleep_word`,1) × F × UNIT clock cycles. F is 1, 8, 16 or 32 for `ext_sel` = 0, 1, 2 or 3. A configuration that already lies below the elapsed count ends the sleep on the next clock.
- R5: Start-up lasts SU[`baud_sel`] clock cycles (parameters SU0..SU3) and then always leads to bit-check.
- R6: In bit-check, a data edge is a rising clock edge at which `data_in` differs from its value at the previous rising edge. The first edge starts the timing. Each following edge closes an interval of k clocks, which passes if P−P/4 ≤ k ≤ P+P/4, where P = P[`baud_sel`] and the division is integer division. After max(`nbits`,1) passing intervals, the block enters receiving on that clock.
- R7: An interval shorter than P−P/4 sends the block to sleep on the clock that closes it.
- R8: If no edge arrives for P+P/4 clocks in bit-check (counted from entry or from the last edge), the block returns to sleep on that clock.
- R9: In receiving, `data_out` follows `data_in` combinationally. In all other phases it is 0.
- R10: When `en_in` is sampled low on two consecutive rising edges in any phase other than sleep, the second edge forces sleep and clears the sleep count. This takes priority over every other transition. A single low sample has no effect. Any `en_in` level during sleep is ignored, and the sleep length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_word | input | 5 | Sleep word |
| ext_sel | input | 2 | Extension factor select (1, 8, 16, 32) |
| baud_sel | input | 2 | Baud-range code |
| nbits | input | BCW | Passing intervals needed for bit-check (0 acts as 1) |
| data_in | input | 1 | Demodulated data line |
| en_in | input | 1 | Enable; low for two clocks is an off command |
| path_en | output | 1 | Signal-path enable |
| data_out | output | 1 | Gated data pass-through |
| state_o | output | 2 | Current phase code |

## Verification
The bench builds the block with UNIT = 4, start-up counts of 5, 7, 9 and 11, and nominal intervals of 8, 12, 16 and 20 clocks. With these values the largest sleep (31 × 32 × 4 = 3968 cycles) fits in a short run. Every baud window, including its lower-edge rejection and its timeout, is reached within a few dozen clocks. The short counts also let several complete sleep, start-up, check and receive loops run back to back. As a result, off commands can be exercised in each non-sleep phase, and a one-clock enable glitch can be tested in receiving.

// File: rtl/rx_poll_ctrl.sv
module rx_poll_ctrl #(
  parameter int UNIT = 1024,
  parameter int CW   = 24,
  parameter int BCW  = 4,
  parameter int SU0  = 256,
  parameter int SU1  = 512,
  parameter int SU2  = 1024,
  parameter int SU3  = 2048,
  parameter int P0   = 64,
  parameter int P1   = 128,
  parameter int P2   = 256,
  parameter int P3   = 512
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [4:0]     sleep_word,
  input  logic [1:0]     ext_sel,
  input  logic [1:0]     baud_sel,
  input  logic [BCW-1:0] nbits,
  input  logic           data_in,
  input  logic           en_in,
  output logic           path_en,
  output logic           data_out,
  output logic [1:0]     state_o
);

  typedef enum logic [1:0] {SLP = 2'd0, STUP = 2'd1, CHK = 2'd2, RCV = 2'd3} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [BCW-1:0] good;
  logic           seen, data_q, en_q;

  logic [4:0]     word;
  logic [2:0]     sh;
  logic [CW-1:0]  sleep_len, su_len, per, pmin, pmax, intv;
  logic [BCW:0]   nb_eff;

  wire off    = !en_in && !en_q;
  wire edge_d = data_in ^ data_q;

  assign word   = (sleep_word == 5'd0) ? 5'd1 : sleep_word;
  assign nb_eff = (nbits == '0) ? (BCW+1)'(1) : {1'b0, nbits};
  assign intv   = cnt + CW'(1);

  always_comb begin
    case (ext_sel)
      2'd0:    sh = 3'd0;
      2'd1:    sh = 3'd3;
      2'd2:    sh = 3'd4;
      default: sh = 3'd5;
    endcase
    case (baud_sel)
      2'd0:    begin su_len = CW'(SU0); per = CW'(P0); end
      2'd1:    begin su_len = CW'(SU1); per = CW'(P1); end
      2'd2:    begin su_len = CW'(SU2); per = CW'(P2); end
      default: begin su_len = CW'(SU3); per = CW'(P3); end
    endcase
  end

  assign sleep_len = (CW'(word) << sh) * CW'(UNIT);
  assign pmin      = per - (per >> 2);
  assign pmax      = per + (per >> 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SLP;
      cnt    <= '0;
      good   <= '0;
      seen   <= 1'b0;
      data_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      data_q <= data_in;
      en_q   <= en_in;
      if (off && st != SLP) begin
        st  <= SLP;
        cnt <= '0;
      end else begin
        case (st)
          SLP: begin
            if (cnt >= sleep_len - CW'(1)) begin
              st  <= STUP;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          end
          STUP: begin
            if (cnt >= su_len - CW'(1)) begin
              st   <= CHK;
              cnt  <= '0;
              good <= '0;
              seen <= 1'b0;
            end else cnt <= cnt + CW'(1);
          end
          CHK: begin
            if (edge_d) begin
              cnt <= '0;
              if (!seen) seen <= 1'b1;
              else if (intv < pmin || intv > pmax) st <= SLP;
              else if ({1'b0, good} + (BCW+1)'(1) >= nb_eff) st <= RCV;
              else good <= good + BCW'(1);
            end else if (cnt >= pmax - CW'(1)) begin
              st  <= SLP;
              cnt <= '0;
            end else cnt <= cnt + CW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o  = st;
  assign path_en  = (st != SLP);
  assign data_out = (st == RCV) && data_in;

endmodule

module rx_poll_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_in,
  input logic       path_en,
  input logic       data_out,
  input logic [1:0] state_o
);

  // R2
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'd0 |=> state_o inside {2'd0, 2'd1});

  // R2
  rcv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o inside {2'd0, 2'd1} |=> state_o != 2'd3);

  // R3
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_en) |-> state_o == 2'd1);

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3 |-> !data_out);

  // R10
  off_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_in && !$past(en_in) && state_o != 2'd0) |=> state_o == 2'd0);

endmodule

bind rx_poll_ctrl rx_poll_ctrl_chk u_chk (.*);

// File: tb/test_rx_poll_ctrl.sv
module test_rx_poll_ctrl;
  localparam int UNIT = 4;
  localparam int SU[4] = '{5, 7, 9, 11};
  localparam int PP[4] = '{8, 12, 16, 20};

  logic clk = 0, rst_n = 0;
  logic [4:0] sleep_word = 2;
  logic [1:0] ext_sel = 1, baud_sel = 0;
  logic [3:0] nbits = 3;
  logic data_in = 1, en_in = 1;
  logic path_en, data_out;
  logic [1:0] state_o;

  int checks = 0, errors = 0, per = 0, tc = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  rx_poll_ctrl #(.UNIT(UNIT), .CW(24), .BCW(4),
    .SU0(5), .SU1(7), .SU2(9), .SU3(11),
    .P0(8), .P1(12), .P2(16), .P3(20)) i_rx_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_word(sleep_word), .ext_sel(ext_sel),
    .baud_sel(baud_sel), .nbits(nbits), .data_in(data_in), .en_in(en_in),
    .path_en(path_en), .data_out(data_out), .state_o(state_o));

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st, m_cnt, m_good, m_seen, m_dq, m_eq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_good = 0; m_seen = 0; m_dq = 0; m_eq = 1;
    end else begin
      int w, f, slen, p, lo, hi, nb;
      bit off, edg;
      w = (sleep_word == 0) ? 1 : int'(sleep_word);
      f = (ext_sel == 0) ? 1 : (ext_sel == 1) ? 8 : (ext_sel == 2) ? 16 : 32;
      slen = w * f * UNIT;
      p = PP[baud_sel]; lo = p - p / 4; hi = p + p / 4;
      nb = (nbits == 0) ? 1 : int'(nbits);
      off = !en_in && (m_eq == 0);
      edg = (int'(data_in) != m_dq);
      m_dq = int'(data_in); m_eq = int'(en_in);
      if (off && m_st != 0) begin m_st = 0; m_cnt = 0; end
      else if (m_st == 0) begin
        if (m_cnt + 1 >= slen) begin m_st = 1; m_cnt = 0; end else m_cnt++;
      end else if (m_st == 1) begin
        if (m_cnt + 1 >= SU[baud_sel]) begin m_st = 2; m_cnt = 0; m_good = 0; m_seen = 0; end
        else m_cnt++;
      end else if (m_st == 2) begin
        if (edg) begin
          if (m_seen == 0) m_seen = 1;
          else if (m_cnt + 1 < lo || m_cnt + 1 > hi) m_st = 0;
          else if (m_good + 1 >= nb) m_st = 3;
          else m_good++;
          m_cnt = 0;
        end else if (m_cnt + 1 >= hi) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end
  end

  always @(negedge clk) if (!done) begin
    chk(cur_req, state_o, m_st, "state");
    chk(cur_req, path_en, (m_st != 0), "path_en");
    chk(cur_req, data_out, (m_st == 3) ? int'(data_in) : 0, "data_out");
  end

  // data toggler: per>0 toggles every per clocks, per<0 random, 0 holds
  initial forever begin
    @(posedge clk); #2;
    if (per > 0) begin
      tc++;
      if (tc >= per) begin data_in = ~data_in; tc = 0; end
    end else if (per < 0) data_in = 1'($urandom);
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wait_st(int s);
    int g = 0;
    while (state_o != 2'(s) && g < 20000) begin @(negedge clk); g++; end
    if (g >= 20000) chk(cur_req, state_o, s, "wait timeout");
  endtask

  task automatic len_of(int s, output int n);
    n = 0;
    while (state_o == 2'(s) && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic off_cmd();
    en_in = 0; cyc(2); en_in = 1;
  endtask

  initial begin
    int a, b;
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a, b;
    cyc(3);
    chk("R1", state_o, 0, "reset state");
    chk("R1", path_en, 0, "reset path_en");
    chk("R1", data_out, 0, "reset data_out");
    data_in = 0;
    rst_n = 1;
    cur_req = "R2 R3 R4 R5";
    per = 8;
    cur_req = "R6";
    @(negedge clk); wait_st(3);
    chk("R6", state_o, 3, "reached receiving");
    cur_req = "R9"; per = -1; cyc(20);
    cur_req = "R10"; en_in = 0; cyc(1); en_in = 1; cyc(4);
    chk("R10", state_o, 3, "single low sample ignored");
    // off, then hold enable low in sleep: must not change sleep length
    per = 8; en_in = 0; cyc(2);
    @(negedge clk);
    fork
      begin cyc(4); en_in = 1; end
      begin len_of(0, a); len_of(1, b); end
    join
    chk("R4", a, 2 * 8 * UNIT, "sleep length word2 ext1");
    chk("R5", b, SU[0], "startup length baud0");
    wait_st(3);
    // too-short intervals
    cur_req = "R7"; off_cmd(); per = 3;
    @(negedge clk); wait_st(2); len_of(2, a);
    chk("R7", state_o, 0, "short interval -> sleep");
    // timeout with held data, shrink sleep meanwhile
    cur_req = "R8"; per = 0; sleep_word = 0; ext_sel = 0;
    wait_st(2); len_of(2, a);
    chk("R8", a, PP[0] + PP[0] / 4, "bit-check timeout length");
    chk("R8", state_o, 0, "timeout -> sleep");
    cur_req = "R4"; len_of(0, a);
    chk("R4", a, UNIT, "sleep length word0 ext0");
    // baud 3, nbits 0 acts as 1
    cur_req = "R6"; baud_sel = 3; nbits = 0; per = 20;
    len_of(1, b);
    chk("R5", b, SU[3], "startup length baud3");
    wait_st(3);
    chk("R6", state_o, 3, "nbits 0 passes after one interval");
    // off during start-up
    cur_req = "R10"; per = 0; off_cmd();
    @(negedge clk); wait_st(1); cyc(1); off_cmd();
    chk("R10", state_o, 0, "off in start-up");
    // longest sleep
    cur_req = "R4"; sleep_word = 31; ext_sel = 3; baud_sel = 1; nbits = 2;
    @(negedge clk); wait_st(1); off_cmd(); @(negedge clk);
    len_of(0, a);
    chk("R4", a, 31 * 32 * UNIT, "sleep length word31 ext3");
    cur_req = "R2"; per = 12; wait_st(3);
    chk("R2", state_o, 3, "full loop baud1");
    cyc(3);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule